// File: doc/BRIEF.md
# Timestamp Counter Read Unit

This block serves timestamp reads for an instruction sequencer. It keeps a free-running counter that is twice the width of a result word, and it also holds a programmable offset of the same width and an auxiliary word. When the sequencer pulses a request, the unit adds the offset to the counter's current value. It returns the sum as a low word and a high word. For the variant of the request that asks for it, the unit also returns the auxiliary word.

Access depends on privilege. A control bit can forbid timestamp reads outside the most privileged level. When that bit is set and the current privilege level is not zero, the request completes with a protection fault and no data. The offset and auxiliary registers are loaded through simple write-enable ports. All results appear one cycle after the request, together with a single-cycle valid pulse.

Top module: `tsc_read_unit`

## Requirements
- R1: After reset is released, the internal counter increases by exactly one on every clock edge and wraps modulo 2^(2*RES_W).
- R2: A synchronous active-high reset clears the counter, the offset register and the auxiliary register to zero. While reset is held, rsp_valid, rsp_fault, rsp_lo, rsp_hi and rsp_aux are all zero.
- R3: A granted request returns the counter value present at the sampling edge plus the offset register, taken modulo 2^(2*RES_W). An offset written in the same cycle as a request affects only requests in later cycles.
- R4: Bits [RES_W-1:0] of the sum appear on rsp_lo, and bits [2*RES_W-1:RES_W] of the sum appear on rsp_hi.
- R5: The req_op encoding is 0 for a plain read and 1 for a read with auxiliary. A granted op 1 drives the auxiliary register onto rsp_aux, and op 0 drives rsp_aux to zero.
- R6: When ts_disable is 1 and cpl is nonzero, the response has rsp_fault = 1, and rsp_lo, rsp_hi and rsp_aux are all zero.
- R7: When ts_disable is 0, or when cpl is 0, a request never faults.
- R8: rsp_valid goes high in the cycle after each request edge, for one cycle per request. Back-to-back requests each produce their own pulse. rsp_fault is never high without rsp_valid.
- R9: An auxiliary write takes effect for requests in the following cycles. The value is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle held high |
| req_op | input | 1 | 0 plain read, 1 read with auxiliary word |
| ts_disable | input | 1 | Forbid reads at nonzero privilege |
| cpl | input | PL_W | Current privilege level, 0 is most privileged |
| off_we | input | 1 | Offset write enable |
| off_wdata | input | 2*RES_W | Offset write value |
| aux_we | input | 1 | Auxiliary write enable |
| aux_wdata | input | RES_W | Auxiliary write value |
| rsp_valid | output | 1 | Response valid pulse |
| rsp_fault | output | 1 | Protection fault for this response |
| rsp_lo | output | RES_W | Low word of counter plus offset |
| rsp_hi | output | RES_W | High word of counter plus offset |
| rsp_aux | output | RES_W | Auxiliary word or zero |

## Verification
The assertions assume that req_op, ts_disable and cpl carry known values in any cycle where req_valid is high. They also assume that reset is asserted for at least one edge before checking starts, because the counter-step and response properties compare against the previous cycle. The stimulus drives every input to a known value from time zero. It changes inputs only at the falling clock edge and holds reset for several cycles, so every sampled request sees stable, defined controls.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int unsigned TSC_RES_W_DEF = 32;
  localparam int unsigned TSC_PL_W_DEF  = 2;

  typedef enum logic {
    TSC_OP_PLAIN = 1'b0,
    TSC_OP_AUX   = 1'b1
  } tsc_op_e;

endpackage

// File: rtl/tsc_free_counter.sv
module tsc_free_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  assign count = count_q;

endmodule

// File: rtl/tsc_wreg.sv
module tsc_wreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (we) begin
      q_r <= wdata;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/tsc_priv_gate.sv
module tsc_priv_gate #(
  parameter int unsigned PL_W = 2
) (
  input  logic            ts_disable,
  input  logic [PL_W-1:0] cpl,
  output logic            grant
);

  // Level zero is always allowed; other levels only if reads are enabled.
  always_comb begin
    grant = 1'b1;
    if (ts_disable && (cpl != '0)) begin
      grant = 1'b0;
    end
  end

endmodule

// File: rtl/tsc_result_stage.sv
module tsc_result_stage
  import tsc_pkg::*;
#(
  parameter int unsigned RES_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  tsc_op_e            req_op,
  input  logic               grant,
  input  logic [2*RES_W-1:0] count,
  input  logic [2*RES_W-1:0] offset,
  input  logic [RES_W-1:0]   aux,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [RES_W-1:0]   rsp_lo,
  output logic [RES_W-1:0]   rsp_hi,
  output logic [RES_W-1:0]   rsp_aux
);

  localparam int unsigned SUM_W = 2 * RES_W;

  logic [SUM_W-1:0] sum;
  logic [RES_W-1:0] aux_sel;

  always_comb begin
    sum     = count + offset;
    aux_sel = (req_op == TSC_OP_AUX) ? aux : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_lo    <= '0;
      rsp_hi    <= '0;
      rsp_aux   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && !grant;
      if (req_valid) begin
        if (grant) begin
          rsp_lo  <= sum[RES_W-1:0];
          rsp_hi  <= sum[SUM_W-1:RES_W];
          rsp_aux <= aux_sel;
        end else begin
          rsp_lo  <= '0;
          rsp_hi  <= '0;
          rsp_aux <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/tsc_read_unit.sv
module tsc_read_unit
  import tsc_pkg::*;
#(
  parameter int unsigned RES_W = TSC_RES_W_DEF,
  parameter int unsigned PL_W  = TSC_PL_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_op,
  input  logic               ts_disable,
  input  logic [PL_W-1:0]    cpl,
  input  logic               off_we,
  input  logic [2*RES_W-1:0] off_wdata,
  input  logic               aux_we,
  input  logic [RES_W-1:0]   aux_wdata,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [RES_W-1:0]   rsp_lo,
  output logic [RES_W-1:0]   rsp_hi,
  output logic [RES_W-1:0]   rsp_aux
);

  localparam int unsigned CNT_W = 2 * RES_W;

  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] off_q;
  logic [RES_W-1:0] aux_q;
  logic             grant;
  tsc_op_e          op_e;

  assign op_e = tsc_op_e'(req_op);

  tsc_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .count (cnt_val)
  );

  tsc_wreg #(.W(CNT_W)) u_off (
    .clk   (clk),
    .rst   (rst),
    .we    (off_we),
    .wdata (off_wdata),
    .q     (off_q)
  );

  tsc_wreg #(.W(RES_W)) u_aux (
    .clk   (clk),
    .rst   (rst),
    .we    (aux_we),
    .wdata (aux_wdata),
    .q     (aux_q)
  );

  tsc_priv_gate #(.PL_W(PL_W)) u_gate (
    .ts_disable (ts_disable),
    .cpl        (cpl),
    .grant      (grant)
  );

  tsc_result_stage #(.RES_W(RES_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (op_e),
    .grant     (grant),
    .count     (cnt_val),
    .offset    (off_q),
    .aux       (aux_q),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_lo    (rsp_lo),
    .rsp_hi    (rsp_hi),
    .rsp_aux   (rsp_aux)
  );

endmodule

// File: rtl/tsc_read_chk.sv
module tsc_read_chk #(
  parameter int unsigned RES_W = 32,
  parameter int unsigned PL_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_op,
  input logic               ts_disable,
  input logic [PL_W-1:0]    cpl,
  input logic [2*RES_W-1:0] cnt,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [RES_W-1:0]   rsp_lo,
  input logic [RES_W-1:0]   rsp_hi,
  input logic [RES_W-1:0]   rsp_aux
);

  logic prev_run = 1'b0;

  always_ff @(posedge clk) begin
    prev_run <= !rst;
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    prev_run |-> (cnt == $past(cnt) + 1'b1));

  // R8
  req_resp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R8
  valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_run && rsp_valid) |-> $past(req_valid));

  // R8
  fault_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid);

  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_run && rsp_fault) |-> ($past(ts_disable) && ($past(cpl) != '0)));

  // R6
  fault_data_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> ((rsp_lo == '0) && (rsp_hi == '0) && (rsp_aux == '0)));

  // R7
  no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_run && rsp_valid && (!$past(ts_disable) || ($past(cpl) == '0))) |-> !rsp_fault);

  // R5
  plain_aux_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_run && rsp_valid && !$past(req_op)) |-> (rsp_aux == '0));

endmodule

bind tsc_read_unit tsc_read_chk #(.RES_W(RES_W), .PL_W(PL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .ts_disable (ts_disable),
  .cpl        (cpl),
  .cnt        (cnt_val),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_lo     (rsp_lo),
  .rsp_hi     (rsp_hi),
  .rsp_aux    (rsp_aux)
);

// File: tb/tsc_read_unit_bench.sv
`timescale 1ns/1ps
module tsc_read_unit_bench;

  localparam int unsigned RES_W = 32;
  localparam int unsigned PL_W  = 2;
  localparam int unsigned CW    = 2 * RES_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_op = 1'b0;
  logic               ts_disable = 1'b0;
  logic [PL_W-1:0]    cpl = '0;
  logic               off_we = 1'b0;
  logic [CW-1:0]      off_wdata = '0;
  logic               aux_we = 1'b0;
  logic [RES_W-1:0]   aux_wdata = '0;
  logic               rsp_valid;
  logic               rsp_fault;
  logic [RES_W-1:0]   rsp_lo;
  logic [RES_W-1:0]   rsp_hi;
  logic [RES_W-1:0]   rsp_aux;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [CW-1:0]    model_cnt = '0;
  logic [CW-1:0]    model_off = '0;
  logic [RES_W-1:0] model_aux = '0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) model_cnt <= '0;
    else     model_cnt <= model_cnt + 1'b1;
  end

  tsc_read_unit #(.RES_W(RES_W), .PL_W(PL_W)) u_tsc_read_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .ts_disable(ts_disable), .cpl(cpl), .off_we(off_we), .off_wdata(off_wdata),
    .aux_we(aux_we), .aux_wdata(aux_wdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi), .rsp_aux(rsp_aux)
  );

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Check a response against the expected operands captured at request time.
  task automatic check_rsp(input logic op, input logic dis, input logic [PL_W-1:0] lvl,
                           input logic [CW-1:0] c, input logic [CW-1:0] o,
                           input logic [RES_W-1:0] a);
    logic            flt;
    logic [CW-1:0]   s;
    flt = dis && (lvl != '0);
    s   = c + o;
    chk("R8 valid", {63'd0, rsp_valid}, 64'd1);
    if (flt) begin
      chk("R6 fault", {63'd0, rsp_fault}, 64'd1);
      chk("R6 data zero", {rsp_hi, rsp_lo}, 64'd0);
      chk("R6 aux zero", {32'd0, rsp_aux}, 64'd0);
    end else begin
      chk("R7 no fault", {63'd0, rsp_fault}, 64'd0);
      chk("R4 low word", {32'd0, rsp_lo}, {32'd0, s[RES_W-1:0]});
      chk("R4 high word", {32'd0, rsp_hi}, {32'd0, s[CW-1:RES_W]});
      chk("R3 sum", {rsp_hi, rsp_lo}, s);
      chk("R5 aux select", {32'd0, rsp_aux}, op ? {32'd0, a} : 64'd0);
    end
  endtask

  task automatic do_req(input logic op, input logic dis, input logic [PL_W-1:0] lvl);
    logic [CW-1:0] c;
    req_valid = 1'b1; req_op = op; ts_disable = dis; cpl = lvl;
    c = model_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(op, dis, lvl, c, model_off, model_aux);
  endtask

  task automatic wr_off(input logic [CW-1:0] v);
    off_we = 1'b1; off_wdata = v;
    @(negedge clk);
    off_we = 1'b0;
    model_off = v;
  endtask

  task automatic wr_aux(input logic [RES_W-1:0] v);
    aux_we = 1'b1; aux_wdata = v;
    @(negedge clk);
    aux_we = 1'b0;
    model_aux = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] offs [4];
    logic [CW-1:0] c0;
    logic [CW-1:0] old_off;
    offs[0] = 64'd0;
    offs[1] = 64'h0000_0001_FFFF_FF00;
    offs[2] = 64'hFFFF_FFFF_FFFF_FFF0;
    offs[3] = 64'h1234_5678_9ABC_DEF0;

    repeat (4) @(negedge clk);
    // R2: outputs during reset
    chk("R2 valid in reset", {63'd0, rsp_valid}, 64'd0);
    chk("R2 fault in reset", {63'd0, rsp_fault}, 64'd0);
    chk("R2 data in reset", {rsp_hi, rsp_lo}, 64'd0);
    chk("R2 aux in reset", {32'd0, rsp_aux}, 64'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R2 / R1: counter starts from zero, offset and aux cleared
    do_req(1'b1, 1'b0, 2'd0);
    chk("R1 counter since reset", {rsp_hi, rsp_lo}, 64'd3);
    @(negedge clk);
    chk("R8 single pulse", {63'd0, rsp_valid}, 64'd0);

    // Sweep offsets, ops, disable bit and privilege levels
    for (int k = 0; k < 4; k++) begin
      wr_off(offs[k]);
      wr_aux(32'hA5A5_0000 ^ 32'(k * 32'h0101_0101));
      for (int op = 0; op < 2; op++) begin
        for (int d = 0; d < 2; d++) begin
          for (int l = 0; l < 4; l++) begin
            do_req(op[0], d[0], l[PL_W-1:0]);
          end
        end
      end
    end

    // R8: back-to-back requests with different operands
    wr_off(64'h0000_0000_0000_0100);
    req_valid = 1'b1; req_op = 1'b0; ts_disable = 1'b0; cpl = 2'd3;
    c0 = model_cnt;
    @(negedge clk);
    check_rsp(1'b0, 1'b0, 2'd3, c0, model_off, model_aux);
    req_op = 1'b1; ts_disable = 1'b1; cpl = 2'd1;
    @(negedge clk);
    check_rsp(1'b1, 1'b1, 2'd1, c0 + 1'b1, model_off, model_aux);
    req_op = 1'b1; ts_disable = 1'b1; cpl = 2'd0;
    @(negedge clk);
    check_rsp(1'b1, 1'b1, 2'd0, c0 + 2'd2, model_off, model_aux);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 pulse ends", {63'd0, rsp_valid}, 64'd0);
    chk("R8 no fault idle", {63'd0, rsp_fault}, 64'd0);

    // R3: offset written with a request uses the old offset
    old_off = model_off;
    req_valid = 1'b1; req_op = 1'b0; ts_disable = 1'b0; cpl = 2'd0;
    off_we = 1'b1; off_wdata = 64'hDEAD_BEEF_0000_0000;
    c0 = model_cnt;
    @(negedge clk);
    req_valid = 1'b0; off_we = 1'b0;
    check_rsp(1'b0, 1'b0, 2'd0, c0, old_off, model_aux);
    model_off = 64'hDEAD_BEEF_0000_0000;
    do_req(1'b0, 1'b0, 2'd0);

    // R9: aux written with a request uses the old aux, then the new one
    req_valid = 1'b1; req_op = 1'b1; ts_disable = 1'b0; cpl = 2'd2;
    aux_we = 1'b1; aux_wdata = 32'h0F0F_F0F0;
    c0 = model_cnt;
    @(negedge clk);
    req_valid = 1'b0; aux_we = 1'b0;
    check_rsp(1'b1, 1'b0, 2'd2, c0, model_off, model_aux);
    model_aux = 32'h0F0F_F0F0;
    do_req(1'b1, 1'b0, 2'd2);
    chk("R9 aux value", {32'd0, rsp_aux}, 64'h0000_0000_0F0F_F0F0);

    // R2: reset again clears offset and aux
    rst = 1'b1;
    @(negedge clk);
    chk("R2 valid cleared", {63'd0, rsp_valid}, 64'd0);
    rst = 1'b0;
    model_off = '0; model_aux = '0;
    do_req(1'b1, 1'b0, 2'd0);
    chk("R2 offset cleared", {rsp_hi, rsp_lo}, 64'd0);
    chk("R2 aux cleared", {32'd0, rsp_aux}, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule